// File: doc/BRIEF.md
# Two-Stage Cascaded Averaging Filter

This block smooths a stream of 14-bit two's-complement samples. Two identical moving-average stages sit in series, so the combined impulse response is a triangle (a Bartlett window) of length 2N-1. Each stage averages the last N = 2^M accepted samples. The running sum is divided by N with an arithmetic right shift, so the quotient is rounded toward minus infinity.

A 3-bit tap field gives M. A 3-bit range field can impose a lower bound on M. The filter then always averages enough samples to keep the resolution that a narrower measurement range needs. A change of the effective M flushes both stages, so averages taken under the old setting never reach the output. With M = 0 the filter is bypassed and each sample appears one cycle after it was accepted.

Top module: `tavg_filter`

## Requirements
- R1: For M > 0, output k is floor(S2/N). S2 is the sum of the last N first-stage results, and each first-stage result is floor(S1/N), where S1 is the sum of the last N accepted input samples.
- R2: M equals the tap field value when no range minimum applies, so tap field 0..7 gives 1..128 taps per stage, and 110 gives 64.
- R3: Range code 100 places no minimum on M. The codes 000, 011, 101, 110 and 111 also place no minimum.
- R4: Range code 010 raises an M below 2 to 2.
- R5: Range code 001 raises an M below 4 to 4.
- R6: Before a stage has accepted N samples since its last flush, its missing older samples count as zero.
- R7: For M > 0, each accepted sample produces exactly one out_valid pulse two cycles later. Cycles with in_valid low produce no output.
- R8: For M = 0, out_data equals the accepted sample and appears one cycle after it.
- R9: A change of the effective M flushes both stages and the output pipeline. A sample offered in the cycle the change is first seen is dropped, and later outputs carry no contribution from samples taken before the change.
- R10: Full-scale inputs do not overflow: a constant input of -8192 or +8191 yields that same value once the window is full.
- R11: During reset out_valid and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 14 | Input sample, two's complement |
| tap_sel | input | 3 | Tap field M, N = 2^M taps per stage |
| range_sel | input | 3 | Range code: 100 full, 010 half (M>=2), 001 quarter (M>=4) |
| out_valid | output | 1 | Filtered sample strobe |
| out_data | output | 14 | Filtered sample, two's complement |

## Verification
The bench goes after the raised tap counts. A limiter that ignored the range code would return averages over too few samples, and those values do not match the model for the raised M. It feeds full-scale constants, where a running sum that is too narrow would wrap and put out a value of the wrong sign. It changes M after a case with large samples and then feeds zeros. A filter that did not flush would put out non-zero tails. It also offers a sample in the same cycle as a change to bypass mode; a design that did not drop it would put out a stray pulse. Latency is measured per sample, so an extra or missing register in either the bypass path or the averaging path shows up as a wrong cycle distance.

// File: rtl/tavg_pkg.sv
package tavg_pkg;

   typedef enum logic [2:0] {
      RNG_QUARTER = 3'b001,
      RNG_HALF    = 3'b010,
      RNG_FULL    = 3'b100
   } range_e;

   localparam int HALF_FLOOR_M    = 2;
   localparam int QUARTER_FLOOR_M = 4;

   // smallest tap exponent a range code allows
   function automatic int floor_m(input logic [2:0] rng);
      case (rng)
         RNG_HALF:    return HALF_FLOOR_M;
         RNG_QUARTER: return QUARTER_FLOOR_M;
         default:     return 0;
      endcase
   endfunction

endpackage

// File: rtl/tavg_cfg.sv
module tavg_cfg #(
   parameter int MW          = 3,
   parameter bit ENFORCE_MIN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] tap_sel,
   input  logic [2:0]    range_sel,
   output logic [MW-1:0] m_q,
   output logic          chg
);
   logic [MW-1:0] m_eff;

   generate
      if (ENFORCE_MIN) begin : g_limit
         int fl;
         always_comb begin
            fl = tavg_pkg::floor_m(range_sel);
            m_eff = (int'(tap_sel) < fl) ? MW'(fl) : tap_sel;
         end

         assert_half_floor_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            (range_sel == tavg_pkg::RNG_HALF) |=> (m_q >= MW'(tavg_pkg::HALF_FLOOR_M)));
         assert_quarter_floor_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (range_sel == tavg_pkg::RNG_QUARTER) |=> (m_q >= MW'(tavg_pkg::QUARTER_FLOOR_M)));
      end else begin : g_free
         assign m_eff = tap_sel;
      end
   endgenerate

   assign chg = (m_eff != m_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '0;
      else        m_q <= m_eff;
   end

endmodule

// File: rtl/tavg_stage.sv
module tavg_stage #(
   parameter int DW    = 14,
   parameter int MW    = 3,
   parameter int MAX_M = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MW-1:0]        m,
   input  logic                 clr,
   input  logic                 i_valid,
   input  logic signed [DW-1:0] i_data,
   output logic                 o_valid,
   output logic signed [DW-1:0] o_data
);
   localparam int AW    = MAX_M;
   localparam int DEPTH = 1 << MAX_M;
   localparam int SW    = DW + MAX_M;

   logic signed [DW-1:0] mem [DEPTH];
   logic [AW-1:0]        ptr;
   logic [AW:0]          cnt;
   logic signed [SW-1:0] sum;

   logic [AW:0]          n_taps;
   logic [AW-1:0]        mask;
   logic                 full;
   logic signed [DW-1:0] old;
   logic signed [SW-1:0] sum_n;

   always_comb begin
      n_taps = (AW+1)'(1) << m;
      mask   = AW'(n_taps - 1'b1);
      full   = (cnt == n_taps);
      old    = full ? mem[ptr] : '0;
      sum_n  = sum + SW'(i_data) - SW'(old);
   end

   always_ff @(posedge clk) begin
      if (i_valid && !clr) mem[ptr] <= i_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         cnt     <= '0;
         sum     <= '0;
         o_valid <= 1'b0;
         o_data  <= '0;
      end else if (clr) begin
         ptr     <= '0;
         cnt     <= '0;
         sum     <= '0;
         o_valid <= 1'b0;
      end else if (i_valid) begin
         ptr     <= (ptr + 1'b1) & mask;
         cnt     <= full ? cnt : cnt + 1'b1;
         sum     <= sum_n;
         o_valid <= 1'b1;
         o_data  <= DW'(sum_n >>> m);
      end else begin
         o_valid <= 1'b0;
      end
   end

   assert_fill_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= n_taps);
   assert_one_out_per_in_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $past(i_valid));
   assert_flush_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!o_valid && cnt == '0));

endmodule

// File: rtl/tavg_filter.sv
module tavg_filter #(
   parameter int DW          = 14,
   parameter int MW          = 3,
   parameter int MAX_M       = 7,
   parameter bit ENFORCE_MIN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [MW-1:0] tap_sel,
   input  logic [2:0]    range_sel,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   localparam int NSTAGE = 2;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("tavg_filter: DW must be at least 2");
      end
      if (MAX_M < (1 << MW) - 1) begin : g_bad_depth
         $error("tavg_filter: MAX_M must cover every tap field value");
      end
      if (ENFORCE_MIN && MAX_M < tavg_pkg::QUARTER_FLOOR_M) begin : g_bad_floor
         $error("tavg_filter: MAX_M below the quarter-range floor");
      end
   endgenerate

   logic [MW-1:0] m_q;
   logic          chg;

   tavg_cfg #(.MW(MW), .ENFORCE_MIN(ENFORCE_MIN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .tap_sel(tap_sel), .range_sel(range_sel),
      .m_q(m_q), .chg(chg)
   );

   logic                 sv [NSTAGE+1];
   logic signed [DW-1:0] sd [NSTAGE+1];

   assign sv[0] = in_valid;
   assign sd[0] = $signed(in_data);

   generate
      for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
         tavg_stage #(.DW(DW), .MW(MW), .MAX_M(MAX_M)) u_stage (
            .clk(clk), .rst_n(rst_n), .m(m_q), .clr(chg),
            .i_valid(sv[g]), .i_data(sd[g]),
            .o_valid(sv[g+1]), .o_data(sd[g+1])
         );
      end
   endgenerate

   logic          byp_v;
   logic [DW-1:0] byp_d;
   logic          bypass;

   assign bypass = (m_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_v <= 1'b0;
         byp_d <= '0;
      end else begin
         byp_v <= in_valid && bypass && !chg;
         if (in_valid && bypass && !chg) byp_d <= in_data;
      end
   end

   assign out_valid = bypass ? byp_v : sv[NSTAGE];
   assign out_data  = bypass ? byp_d : sd[NSTAGE];

   assert_latency_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && out_valid) |-> $past(in_valid, 2));
   assert_bypass_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && out_valid) |-> ($past(in_valid) && out_data == $past(in_data)));
   assert_change_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !out_valid);

endmodule

// File: tb/tb_tavg_filter.sv
`timescale 1ns/1ps
module tb_tavg_filter;
   localparam int LEN = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] in_data = '0;
   logic [2:0]  tap_sel = '0;
   logic [2:0]  range_sel = 3'b100;
   logic        out_valid;
   logic [13:0] out_data;

   always #2 clk = ~clk;

   tavg_filter dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tap_sel(tap_sel), .range_sel(range_sel),
      .out_valid(out_valid), .out_data(out_data)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   int xs [LEN];
   int in_cyc [LEN];
   int y1 [LEN];
   int y2 [LEN];
   int got [LEN+8];
   int got_cyc [LEN+8];
   int n_out = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (n_out < LEN + 8) begin
            got[n_out] = int'($signed(out_data));
            got_cyc[n_out] = cyc;
         end
         n_out = n_out + 1;
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual cyc=%0d expected finish before 150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // pattern: 0 pseudo-random, 1 constant -8192, 2 constant +8191, 3 zeros
   task automatic run_case(input logic [2:0] tap, input logic [2:0] rng, input int m,
                           input int pat, input bit gaps, input string tag);
      logic [15:0] lf = 16'hACE1;
      int n = 1 << m;
      int s;
      int bad_lat = 0;
      @(negedge clk);
      tap_sel = tap;
      range_sel = rng;
      repeat (3) @(negedge clk);
      n_out = 0;
      for (int k = 0; k < LEN; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (pat)
            0: xs[k] = int'($signed(lf[13:0]));
            1: xs[k] = -8192;
            2: xs[k] = 8191;
            default: xs[k] = 0;
         endcase
      end
      if (pat == 0) begin
         xs[5] = 8191;
         xs[6] = -8192;
      end
      for (int k = 0; k < LEN; k++) begin
         in_valid = 1'b1;
         in_data = 14'(xs[k]);
         in_cyc[k] = cyc;
         @(negedge clk);
         if (gaps && (k % 3 == 2)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      // model: two floor averages over zero-padded windows
      for (int k = 0; k < LEN; k++) begin
         s = 0;
         for (int j = 0; j < n; j++) if (k - j >= 0) s += xs[k-j];
         y1[k] = s >>> m;
      end
      for (int k = 0; k < LEN; k++) begin
         s = 0;
         for (int j = 0; j < n; j++) if (k - j >= 0) s += y1[k-j];
         y2[k] = (m == 0) ? xs[k] : (s >>> m);
      end
      check(n_out == LEN, {tag, " R7 output count"}, n_out, LEN);
      for (int k = 0; k < LEN && k < n_out; k++) begin
         check(got[k] == y2[k], {tag, " R1 R6 value"}, got[k], y2[k]);
         if (got_cyc[k] - in_cyc[k] != ((m == 0) ? 1 : 2)) bad_lat++;
      end
      check(bad_lat == 0, {tag, (m == 0) ? " R8 latency" : " R7 latency"}, bad_lat, 0);
   endtask

   // {tap, range, expected M, pattern, gaps}
   localparam logic [11:0] CASES [9] = '{
      {3'd0, 3'b100, 3'd0, 2'd0, 1'b0},   // R8 bypass
      {3'd1, 3'b100, 3'd1, 2'd0, 1'b1},   // R2 R3
      {3'd3, 3'b100, 3'd3, 2'd0, 1'b0},   // R1
      {3'd1, 3'b010, 3'd2, 2'd0, 1'b0},   // R4 raised
      {3'd2, 3'b001, 3'd4, 2'd0, 1'b1},   // R5 raised
      {3'd6, 3'b010, 3'd6, 2'd0, 1'b0},   // R2 64 taps
      {3'd5, 3'b001, 3'd5, 2'd0, 1'b0},   // R5 above floor
      {3'd1, 3'b111, 3'd1, 2'd0, 1'b0},   // R3 unknown code
      {3'd7, 3'b100, 3'd7, 2'd0, 1'b1}    // R2 128 taps
   };

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);
      check(out_data == 14'd0, "R11 reset out_data", int'(out_data), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      n_out = 0;
      repeat (5) @(negedge clk);
      check(n_out == 0, "R7 idle no output", n_out, 0);

      for (int i = 0; i < 9; i++) begin
         logic [11:0] c = CASES[i];
         run_case(c[11:9], c[8:6], int'(c[5:3]), int'(c[2:1]), c[0],
                  $sformatf("case%0d", i));
      end

      run_case(3'd3, 3'b100, 3, 1, 1'b0, "R10 neg full scale");
      run_case(3'd4, 3'b100, 4, 2, 1'b0, "R10 pos full scale");
      run_case(3'd2, 3'b100, 2, 2, 1'b0, "R9 prefill");
      run_case(3'd3, 3'b100, 3, 3, 1'b0, "R9 flush to zeros");

      // sample offered in the same cycle as a switch into bypass must be dropped
      run_case(3'd4, 3'b100, 4, 0, 1'b0, "R9 setup");
      @(negedge clk);
      n_out = 0;
      tap_sel = 3'd0;
      in_valid = 1'b1;
      in_data = 14'd1234;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(n_out == 0, "R9 change-cycle sample dropped", n_out, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule